// File: doc/BRIEF.md
# Counter-Driven Scan Output Selector

This block reduces the parallel scan-out of several scan chains to one observed bit per shift cycle. A wrapping index counter drives an N-to-1 multiplexer. At the start of each observation path a start chain index is loaded. From then on, every shift cycle moves the index by a signed step, modulo the number of chains.

In static mode one fixed step, set by a parameter, applies for the whole scan-out. In dynamic mode a small op code presented on each shift cycle picks the step from a configured table of signed steps. An op code outside the table holds the index. The default table maps op 0 to +1, op 1 to -1 and op 2 to -2. The default static step is +1 and the default chain count is 5, which is not a power of two.

Top module: `scan_obs_selector`

## Requirements
- R1: `obs_valid` is high exactly on cycles where `shift_en` is high, and on those cycles `obs_bit` equals `chain_out[k]`, where k is the currently selected chain index.
- R2: After reset the index is 0 and not yet stepped, so the first shift cycle without a load observes `chain_out[0]`.
- R3: On a cycle with `load` and `shift_en` both high, the chain at `start_idx` is observed in that same cycle, whatever the mode and op code.
- R4: A `load` with `shift_en` low stores `start_idx`, and the next shift cycle observes that chain without stepping.
- R5: In static mode (`dyn_mode` = 0), each shift cycle that is not a load observes (previous index + STATIC_STEP) mod N, and `op` has no effect.
- R6: In dynamic mode (`dyn_mode` = 1), each shift cycle that is not a load steps the index by the table entry for `op` (default: op 0 = +1, op 1 = -1, op 2 = -2).
- R7: In dynamic mode, an op code value of N_OPS or above (default: 3) leaves the index unchanged for that cycle.
- R8: Stepping wraps in both directions: +1 from N-1 gives 0, -1 from 0 gives N-1, and -2 from 1 gives N-1. The index never leaves 0..N-1.
- R9: While `shift_en` and `load` are both low, the index does not change and `obs_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chain_out | input | N_CHAINS | Current scan-out bit of each chain |
| shift_en | input | 1 | Scan shift cycle |
| load | input | 1 | Load the start index for a new observation path |
| start_idx | input | IDX_W | Start chain index, 0..N_CHAINS-1 |
| dyn_mode | input | 1 | 0 selects the static step, 1 selects the per-cycle op code |
| op | input | OP_W | Per-cycle step selector used in dynamic mode |
| obs_bit | output | 1 | Observed response bit |
| obs_valid | output | 1 | High when `obs_bit` is a sample of the current shift cycle |

## Verification
On every shift cycle the bench drives the chain inputs with a one-hot pattern placed at the expected chain, and then with its inverse. A wrong index therefore shows up both as a missing 1 and as a spurious 0. Static walks start from each chain while the op code changes, which shows whether `op` is ignored. Dynamic walks use mixed op sequences that include the hold code, which separates the +1, -1 and -2 steps from one another. Directed loads at 0, 1 and N-1, and idle gaps with and without a pending load, cover the wrap points and the R4 and R9 paths.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;
  // Width of an index that must hold values 0..n-1 (at least one bit).
  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/scan_sel_step_decode.sv
module scan_sel_step_decode #(
  parameter int N_OPS = 3,
  parameter int OP_W = 2,
  parameter int STEP_W = 4,
  parameter logic [N_OPS*STEP_W-1:0] OP_SET = '0,
  parameter int STATIC_STEP = 1
) (
  input  logic                     dyn_mode,
  input  logic [OP_W-1:0]          op,
  output logic signed [STEP_W-1:0] step
);
  localparam int TBL_SIZE = 1 << OP_W;

  logic signed [STEP_W-1:0] tbl [TBL_SIZE];

  // Table of selectable steps; codes past N_OPS map to a hold step.
  for (genvar g = 0; g < TBL_SIZE; g++) begin : g_tbl
    if (g < N_OPS) begin : g_used
      assign tbl[g] = $signed(OP_SET[g*STEP_W +: STEP_W]);
    end else begin : g_hold
      assign tbl[g] = '0;
    end
  end

  always_comb begin
    if (dyn_mode) step = tbl[op];
    else          step = STEP_W'(STATIC_STEP);
  end
endmodule

// File: rtl/scan_sel_stepper.sv
module scan_sel_stepper #(
  parameter int N_CHAINS = 5,
  parameter int IDX_W = 3,
  parameter int STEP_W = 4
) (
  input  logic [IDX_W-1:0]         cur,
  input  logic signed [STEP_W-1:0] step,
  output logic [IDX_W-1:0]         nxt
);
  localparam int SUM_W = ((IDX_W > STEP_W) ? IDX_W : STEP_W) + 2;
  localparam logic [SUM_W-1:0] N_EXT = SUM_W'(N_CHAINS);

  logic [STEP_W-1:0] neg_step;
  logic [SUM_W-1:0]  mag;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  red;

  // Negative steps add N first so the sum never goes below zero.
  always_comb begin
    neg_step = -step;
    mag = step[STEP_W-1] ? SUM_W'(neg_step) : SUM_W'(step);
    if (step[STEP_W-1]) sum = SUM_W'(cur) + N_EXT - mag;
    else                sum = SUM_W'(cur) + mag;
    red = (sum >= N_EXT) ? (sum - N_EXT) : sum;
    nxt = red[IDX_W-1:0];
  end
endmodule

// File: rtl/scan_sel_chain_mux.sv
module scan_sel_chain_mux #(
  parameter int N_CHAINS = 5,
  parameter int IDX_W = 3
) (
  input  logic [N_CHAINS-1:0] chain_out,
  input  logic [IDX_W-1:0]    sel,
  output logic                obs
);
  always_comb begin
    obs = 1'b0;
    for (int i = 0; i < N_CHAINS; i++) begin
      if (sel == IDX_W'(i)) obs = chain_out[i];
    end
  end
endmodule

// File: rtl/scan_obs_selector.sv
module scan_obs_selector
  import scan_sel_pkg::*;
#(
  parameter int N_CHAINS = 5,
  parameter int STEP_W = 4,
  parameter int N_OPS = 3,
  parameter logic [N_OPS*STEP_W-1:0] OP_SET = 12'hEF1,
  parameter int STATIC_STEP = 1,
  localparam int IDX_W = idx_width(N_CHAINS),
  localparam int OP_W = idx_width(N_OPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CHAINS-1:0] chain_out,
  input  logic                shift_en,
  input  logic                load,
  input  logic [IDX_W-1:0]    start_idx,
  input  logic                dyn_mode,
  input  logic [OP_W-1:0]     op,
  output logic                obs_bit,
  output logic                obs_valid
);
  logic signed [STEP_W-1:0] step;
  logic [IDX_W-1:0] idx_q, idx_d, stepped, sel_idx;
  logic fresh_q, fresh_d, upd_en;

  scan_sel_step_decode #(
    .N_OPS(N_OPS), .OP_W(OP_W), .STEP_W(STEP_W),
    .OP_SET(OP_SET), .STATIC_STEP(STATIC_STEP)
  ) u_dec (
    .dyn_mode(dyn_mode), .op(op), .step(step)
  );

  scan_sel_stepper #(
    .N_CHAINS(N_CHAINS), .IDX_W(IDX_W), .STEP_W(STEP_W)
  ) u_step (
    .cur(idx_q), .step(step), .nxt(stepped)
  );

  scan_sel_chain_mux #(
    .N_CHAINS(N_CHAINS), .IDX_W(IDX_W)
  ) u_mux (
    .chain_out(chain_out), .sel(sel_idx), .obs(obs_bit)
  );

  // A load wins; a stored but unused start index is observed once unstepped.
  always_comb begin
    if (load)         sel_idx = start_idx;
    else if (fresh_q) sel_idx = idx_q;
    else              sel_idx = stepped;
  end

  always_comb begin
    idx_d   = idx_q;
    fresh_d = fresh_q;
    upd_en  = shift_en | load;
    if (shift_en) begin
      idx_d   = sel_idx;
      fresh_d = 1'b0;
    end else if (load) begin
      idx_d   = start_idx;
      fresh_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      fresh_q <= 1'b1;
    end else if (upd_en) begin
      idx_q   <= idx_d;
      fresh_q <= fresh_d;
    end
  end

  assign obs_valid = shift_en;
endmodule

// File: rtl/scan_obs_selector_chk.sv
module scan_obs_selector_chk #(
  parameter int N_CHAINS = 5,
  parameter int IDX_W = 3,
  parameter int OP_W = 2,
  parameter int N_OPS = 3,
  parameter int STATIC_STEP = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_CHAINS-1:0] chain_out,
  input logic                shift_en,
  input logic                load,
  input logic [IDX_W-1:0]    start_idx,
  input logic                dyn_mode,
  input logic [OP_W-1:0]     op,
  input logic                obs_bit,
  input logic [IDX_W-1:0]    sel_idx,
  input logic [IDX_W-1:0]    idx_q
);
  logic             prev_shift_q;
  logic [IDX_W-1:0] prev_sel_q;
  int               exp_static;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_shift_q <= 1'b0;
      prev_sel_q   <= '0;
    end else begin
      prev_shift_q <= shift_en;
      prev_sel_q   <= sel_idx;
    end
  end

  always_comb exp_static = ((int'(prev_sel_q) + STATIC_STEP) % N_CHAINS + N_CHAINS) % N_CHAINS;

  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < N_CHAINS);

  assert_load_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && shift_en && int'(start_idx) < N_CHAINS) |-> obs_bit == chain_out[start_idx]);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load) |=> $stable(idx_q));

  assert_static_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load && !dyn_mode && prev_shift_q) |-> int'(sel_idx) == exp_static);

  assert_reserved_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load && dyn_mode && prev_shift_q && int'(op) >= N_OPS) |-> sel_idx == prev_sel_q);
endmodule

bind scan_obs_selector scan_obs_selector_chk #(
  .N_CHAINS(N_CHAINS), .IDX_W(IDX_W), .OP_W(OP_W),
  .N_OPS(N_OPS), .STATIC_STEP(STATIC_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_out(chain_out), .shift_en(shift_en),
  .load(load), .start_idx(start_idx), .dyn_mode(dyn_mode), .op(op),
  .obs_bit(obs_bit), .sel_idx(sel_idx), .idx_q(idx_q)
);

// File: tb/tb_scan_obs_selector.sv
module tb_scan_obs_selector;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] chain_out;
  logic shift_en, load, dyn_mode;
  logic [2:0] start_idx;
  logic [1:0] op;
  logic obs_bit, obs_valid;

  int checks = 0;
  int fails = 0;
  int cur_m = 0;
  bit fresh_m = 1'b1;

  always #10 clk = ~clk;

  scan_obs_selector dut (
    .clk(clk), .rst_n(rst_n), .chain_out(chain_out), .shift_en(shift_en),
    .load(load), .start_idx(start_idx), .dyn_mode(dyn_mode), .op(op),
    .obs_bit(obs_bit), .obs_valid(obs_valid)
  );

  function automatic int step_of(input bit dm, input int o);
    if (!dm) return 1;
    case (o)
      0: return 1;
      1: return -1;
      2: return -2;
      default: return 0;
    endcase
  endfunction

  function automatic int wrap(input int v);
    return ((v % N) + N) % N;
  endfunction

  task automatic chk(input bit got, input bit exp, input string req, input int sel);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (chain %0d)", req, got, exp, sel);
    end
  endtask

  task automatic cyc(input bit ld, input int st, input bit se, input bit dm,
                     input int o, input string req);
    int exp_sel;
    @(negedge clk);
    load = ld; start_idx = 3'(st); shift_en = se; dyn_mode = dm; op = 2'(o);
    if (ld)           exp_sel = st;
    else if (fresh_m) exp_sel = cur_m;
    else              exp_sel = wrap(cur_m + step_of(dm, o));
    chain_out = N'(1) << exp_sel;
    #2;
    chk(obs_valid, se, req, exp_sel);
    if (se) begin
      chk(obs_bit, 1'b1, req, exp_sel);
      chain_out = ~(N'(1) << exp_sel);
      #2;
      chk(obs_bit, 1'b0, req, exp_sel);
    end
    if (se) begin
      cur_m = exp_sel; fresh_m = 1'b0;
    end else if (ld) begin
      cur_m = st; fresh_m = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; shift_en = 1'b0; load = 1'b0; dyn_mode = 1'b0;
    start_idx = '0; op = '0; chain_out = '0;
    repeat (3) @(posedge clk);
    #2;
    chk(obs_valid, 1'b0, "R2", 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: first shift after reset observes chain 0, then static walk
    cyc(0, 0, 1, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, "R5");
    // Static walks from every start with op churning (R5, R8 wrap at N-1)
    for (int s = 0; s < N; s++) begin
      cyc(1, s, 1, 0, s % 4, "R3");
      for (int k = 1; k < 7; k++) cyc(0, 0, 1, 0, k % 4, "R5");
    end
    // R9: idle gap keeps the index, walk resumes
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 1, 0, 0, "R9");
    // R4: load while idle, then observed unstepped
    cyc(1, 3, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 2, "R4");
    cyc(0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, "R5");
    // Dynamic walks with mixed ops including the hold code
    for (int s = 0; s < N; s++) begin
      cyc(1, s, 1, 1, 2, "R3");
      for (int k = 0; k < 12; k++) begin
        int o;
        o = (k * 7 + s) % 4;
        cyc(0, 0, 1, 1, o, (o == 3) ? "R7" : "R6");
      end
    end
    // R8: wrap points in dynamic mode
    cyc(1, 0, 1, 1, 0, "R3");
    cyc(0, 0, 1, 1, 1, "R8");
    cyc(1, 1, 1, 1, 0, "R3");
    cyc(0, 0, 1, 1, 2, "R8");
    cyc(1, N - 1, 1, 1, 0, "R3");
    cyc(0, 0, 1, 1, 0, "R8");
    cyc(0, 0, 1, 1, 3, "R7");
    cyc(0, 0, 1, 1, 2, "R6");
    cyc(0, 0, 0, 1, 0, "R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule